// File: doc/BRIEF.md
# EPROM Programming Sequence Controller

This block drives the programming pins of a microcontroller's on-chip EPROM while that chip is held in reset. A host writes or reads back one byte at a time. Each request carries a program-or-verify select, a mode code, a 16-bit address and, for a write, a data byte. The controller opens a programming session on the first request. It keeps the session open across later requests, so writes and read-backs can be mixed, and it closes the session only when the host asks.

On the target side the controller produces a reset line, the active-low program-store strobe, the active-low latch/program strobe, a mode byte, two address bytes, and a data byte with its own output enable and input path. It also produces a request for the high programming voltage on the external-access pin. The controller fixes the order of every pin change. The programming voltage is always up before the program strobe falls and always down, with a settle time, before the operation is reported done. Because of that, a read-back can never overlap it. All delays are clock counts set by parameters.

Top module: `eprom_seq_ctrl`

## Requirements
- R1: Outside a session, and out of reset, the target reset is low, both active-low strobes are high, the mode byte is FFh, the voltage request and data output enable are off, and `busy` and `done` are low.
- R2: An accepted start outside a session raises target reset, holds the store strobe high for exactly `PREP_CYC` cycles (at least 2), then drives it low and keeps it low until the session closes.
- R3: The mode byte carries the request's mode code, unchanged, for every cycle of a program or verify operation. At all other times it is FFh.
- R4: The address high byte appears on `tgt_p1` and the low byte on `tgt_p3`. During a program operation the write byte appears on `tgt_p2_out` with `tgt_p2_oe` high.
- R5: A program operation raises the voltage request for exactly `T_SETUP` cycles before the program strobe goes low. The strobe then stays low for exactly `T_PULSE` cycles, and the voltage request stays high throughout the pulse.
- R6: After the pulse the voltage request is off for exactly `T_SETTLE` busy cycles before `done`. The program latency from the start edge to the `done` edge is `T_SETUP+T_PULSE+T_SETTLE`, plus `PREP_CYC` if the start opened the session.
- R7: A verify operation keeps the data output enable and the voltage request off. It returns, on `rdata`, the target data byte present during the access window. Its latency is `T_ACCESS`, plus `PREP_CYC` if the start opened the session.
- R8: A start or close that arrives while `busy` is high is ignored. The address, data and session state are unchanged, and no extra operation follows.
- R9: A close while a session is open and idle returns all pins to the released state of R1 in the next cycle. A later start opens a new session with the `PREP_CYC` preamble.
- R10: `busy` is high from the edge that accepts a start until the edge that raises `done`. `done` is a single-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Request one operation |
| cmd_prog | input | 1 | 1 = program, 0 = verify |
| cmd_mode | input | 8 | Mode code for the mode byte |
| cmd_addr | input | 16 | Byte address |
| cmd_wdata | input | 8 | Byte to program |
| cmd_close | input | 1 | End the open session |
| rdata | output | 8 | Byte read by the last verify |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| tgt_rst | output | 1 | Target reset, active high |
| tgt_psen_n | output | 1 | Program-store strobe, active low |
| tgt_prog_n | output | 1 | Latch/program strobe, active low |
| tgt_p0 | output | 8 | Mode byte |
| tgt_p1 | output | 8 | Address high byte |
| tgt_p3 | output | 8 | Address low byte |
| tgt_p2_out | output | 8 | Data byte to target |
| tgt_p2_oe | output | 1 | Data byte output enable |
| tgt_p2_in | input | 8 | Data byte from target |
| tgt_vpp_en | output | 1 | High programming voltage request |

## Verification
The `done` pulse is due a fixed number of edges after the start edge. That number is `PREP_CYC` for a fresh session plus `T_SETUP+T_PULSE+T_SETTLE` for a program or `T_ACCESS` for a verify. The bench samples at falling edges and counts them from the start, so it expects `done` on count latency+1 exactly. The preamble, setup, pulse and settle widths are measured from run lengths of the sampled pins. Each is compared with its own parameter when the next phase begins. Read data, address bytes and write data are compared on the sample that shows `done`, against a shadow memory that the bench keeps on its own.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_PREP,
      ST_READY,
      ST_SETUP,
      ST_PULSE,
      ST_SETTLE,
      ST_ACCESS
   } seq_st_t;

   function automatic logic in_op(seq_st_t s);
      return (s == ST_SETUP) || (s == ST_PULSE) ||
             (s == ST_SETTLE) || (s == ST_ACCESS);
   endfunction

   function automatic logic in_write(seq_st_t s);
      return (s == ST_SETUP) || (s == ST_PULSE) || (s == ST_SETTLE);
   endfunction

   function automatic int max4(int a, int b, int c, int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/eps_timer.sv
module eps_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/eps_fsm.sv
module eps_fsm
   import eprom_seq_pkg::*;
#(
   parameter int PREP_CYC = 2,
   parameter int T_SETUP  = 3,
   parameter int T_PULSE  = 4,
   parameter int T_SETTLE = 2,
   parameter int T_ACCESS = 2,
   parameter int CNT_W    = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    start_prog,
   input  logic    close,
   input  logic    op_prog,
   output seq_st_t st,
   output logic    accept,
   output logic    capture,
   output logic    done
);
   seq_st_t          nxt;
   logic             t_zero;
   logic             t_load;
   logic [CNT_W-1:0] t_val;

   assign accept  = start && ((st == ST_OFF) || (st == ST_READY));
   assign capture = (st == ST_ACCESS) && t_zero;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_OFF:    if (start) nxt = ST_PREP;
         ST_PREP:   if (t_zero) nxt = op_prog ? ST_SETUP : ST_ACCESS;
         ST_READY: begin
            if (start)      nxt = start_prog ? ST_SETUP : ST_ACCESS;
            else if (close) nxt = ST_OFF;
         end
         ST_SETUP:  if (t_zero) nxt = ST_PULSE;
         ST_PULSE:  if (t_zero) nxt = ST_SETTLE;
         ST_SETTLE: if (t_zero) nxt = ST_READY;
         ST_ACCESS: if (t_zero) nxt = ST_READY;
         default:   nxt = ST_OFF;
      endcase
   end

   always_comb begin
      t_load = (nxt != st);
      unique case (nxt)
         ST_PREP:   t_val = CNT_W'(PREP_CYC - 1);
         ST_SETUP:  t_val = CNT_W'(T_SETUP - 1);
         ST_PULSE:  t_val = CNT_W'(T_PULSE - 1);
         ST_SETTLE: t_val = CNT_W'(T_SETTLE - 1);
         ST_ACCESS: t_val = CNT_W'(T_ACCESS - 1);
         default:   t_val = '0;
      endcase
   end

   eps_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_OFF;
         done <= 1'b0;
      end else begin
         st   <= nxt;
         done <= ((st == ST_SETTLE) || (st == ST_ACCESS)) && t_zero;
      end
   end
endmodule

// File: rtl/eprom_seq_ctrl.sv
module eprom_seq_ctrl
   import eprom_seq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MODE_W   = 8,
   parameter int PREP_CYC = 2,
   parameter int T_SETUP  = 3,
   parameter int T_PULSE  = 4,
   parameter int T_SETTLE = 2,
   parameter int T_ACCESS = 2,
   parameter bit SYNC_IN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_start,
   input  logic                cmd_prog,
   input  logic [MODE_W-1:0]   cmd_mode,
   input  logic [2*DATA_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0]   cmd_wdata,
   input  logic                cmd_close,
   output logic [DATA_W-1:0]   rdata,
   output logic                busy,
   output logic                done,
   output logic                tgt_rst,
   output logic                tgt_psen_n,
   output logic                tgt_prog_n,
   output logic [MODE_W-1:0]   tgt_p0,
   output logic [DATA_W-1:0]   tgt_p1,
   output logic [DATA_W-1:0]   tgt_p3,
   output logic [DATA_W-1:0]   tgt_p2_out,
   output logic                tgt_p2_oe,
   input  logic [DATA_W-1:0]   tgt_p2_in,
   output logic                tgt_vpp_en
);
   localparam int ADDR_W  = 2 * DATA_W;
   localparam int MAX_DUR = max4(max4(PREP_CYC, T_SETUP, T_PULSE, T_SETTLE),
                                 T_ACCESS, 1, 1);
   localparam int CNT_W   = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR);

   if (PREP_CYC < 2) begin : g_bad_prep
      $error("PREP_CYC must be at least 2");
   end
   if (T_SETUP < 1 || T_PULSE < 1 || T_SETTLE < 1 || T_ACCESS < 1) begin : g_bad_dur
      $error("every phase duration must be at least one cycle");
   end
   if (DATA_W < 1 || MODE_W < 1) begin : g_bad_width
      $error("port widths must be positive");
   end

   seq_st_t             st;
   logic                accept;
   logic                capture;
   logic                prog_q;
   logic [MODE_W-1:0]   mode_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   p2_s;

   eps_fsm #(
      .PREP_CYC (PREP_CYC),
      .T_SETUP  (T_SETUP),
      .T_PULSE  (T_PULSE),
      .T_SETTLE (T_SETTLE),
      .T_ACCESS (T_ACCESS),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (cmd_start),
      .start_prog (cmd_prog),
      .close      (cmd_close),
      .op_prog    (prog_q),
      .st         (st),
      .accept     (accept),
      .capture    (capture),
      .done       (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_q  <= 1'b0;
         mode_q  <= '1;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         prog_q  <= cmd_prog;
         mode_q  <= cmd_mode;
         addr_q  <= cmd_addr;
         wdata_q <= cmd_wdata;
      end
   end

   if (SYNC_IN) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p2_s <= '0;
         else        p2_s <= tgt_p2_in;
      end
   end else begin : g_in_dir
      assign p2_s = tgt_p2_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= p2_s;
   end

   always_comb begin
      busy       = in_op(st) || (st == ST_PREP);
      tgt_rst    = (st != ST_OFF);
      tgt_psen_n = (st == ST_OFF) || (st == ST_PREP);
      tgt_prog_n = (st != ST_PULSE);
      tgt_vpp_en = (st == ST_SETUP) || (st == ST_PULSE);
      tgt_p2_oe  = in_write(st);
      tgt_p0     = in_op(st) ? mode_q : '1;
      tgt_p1     = addr_q[ADDR_W-1:DATA_W];
      tgt_p3     = addr_q[DATA_W-1:0];
      tgt_p2_out = wdata_q;
   end
endmodule

// File: rtl/eprom_seq_chk.sv
module eprom_seq_chk #(
   parameter int DATA_W = 8,
   parameter int MODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_start,
   input logic              busy,
   input logic              done,
   input logic              tgt_rst,
   input logic              tgt_psen_n,
   input logic              tgt_prog_n,
   input logic [MODE_W-1:0] tgt_p0,
   input logic [DATA_W-1:0] tgt_p1,
   input logic [DATA_W-1:0] tgt_p3,
   input logic [DATA_W-1:0] tgt_p2_out,
   input logic              tgt_p2_oe,
   input logic              tgt_vpp_en
);
   // R1
   released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_rst |-> (tgt_psen_n && tgt_prog_n && (tgt_p0 == '1) &&
                    !tgt_vpp_en && !tgt_p2_oe && !busy && !done));

   // R2
   psen_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tgt_psen_n) |-> ($past(tgt_rst) && $past(tgt_rst, 2) &&
                             $past(tgt_psen_n, 2)));

   // R3
   mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !tgt_psen_n && !$past(tgt_psen_n))
         |-> $stable(tgt_p0));

   // R5
   prog_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_prog_n |-> (tgt_vpp_en && tgt_p2_oe));

   // R6
   done_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!tgt_vpp_en && tgt_prog_n));

   // R7
   vpp_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_vpp_en |-> tgt_p2_oe);

   // R8
   fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(tgt_p1) && $stable(tgt_p3) &&
                                 $stable(tgt_p2_out)));

   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_start));

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind eprom_seq_ctrl eprom_seq_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_start  (cmd_start),
   .busy       (busy),
   .done       (done),
   .tgt_rst    (tgt_rst),
   .tgt_psen_n (tgt_psen_n),
   .tgt_prog_n (tgt_prog_n),
   .tgt_p0     (tgt_p0),
   .tgt_p1     (tgt_p1),
   .tgt_p3     (tgt_p3),
   .tgt_p2_out (tgt_p2_out),
   .tgt_p2_oe  (tgt_p2_oe),
   .tgt_vpp_en (tgt_vpp_en)
);

// File: tb/eprom_seq_ctrl_bench.sv
module eprom_seq_ctrl_bench;
   localparam int PREP = 2, TS = 3, TW = 4, TT = 2, TA = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 1'b0, cmd_prog = 1'b0, cmd_close = 1'b0;
   logic [7:0]  cmd_mode = 8'h00, cmd_wdata = 8'h00;
   logic [15:0] cmd_addr = 16'h0000;
   logic [7:0]  rdata, tgt_p0, tgt_p1, tgt_p3, tgt_p2_out, tgt_p2_in;
   logic busy, done, tgt_rst, tgt_psen_n, tgt_prog_n, tgt_p2_oe, tgt_vpp_en;

   int total = 0, bad = 0;
   logic [7:0] tgt_mem [256];
   logic [7:0] exp_mem [256];
   logic sess_open = 1'b0;
   logic cur_prog = 1'b0;
   logic [7:0] cur_mode = 8'hFF;

   always #5 clk = ~clk;

   eprom_seq_ctrl #(.PREP_CYC(PREP), .T_SETUP(TS), .T_PULSE(TW),
                    .T_SETTLE(TT), .T_ACCESS(TA)) u_eprom_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_prog(cmd_prog),
      .cmd_mode(cmd_mode), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_close(cmd_close), .rdata(rdata), .busy(busy), .done(done),
      .tgt_rst(tgt_rst), .tgt_psen_n(tgt_psen_n), .tgt_prog_n(tgt_prog_n),
      .tgt_p0(tgt_p0), .tgt_p1(tgt_p1), .tgt_p3(tgt_p3),
      .tgt_p2_out(tgt_p2_out), .tgt_p2_oe(tgt_p2_oe), .tgt_p2_in(tgt_p2_in),
      .tgt_vpp_en(tgt_vpp_en));

   // target model: drives the data byte when the controller does not
   assign tgt_p2_in = tgt_p2_oe ? 8'h00 : tgt_mem[tgt_p3];

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int latency(input logic prog, input logic opened);
      return (opened ? 0 : PREP) + (prog ? TS + TW + TT : TA);
   endfunction

   // pin-sequence monitor
   int prep_cnt = 0, vpp_cnt = 0, low_cnt = 0, settle_cnt = 0;
   logic prev_psen = 1'b1, prev_prog = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!tgt_rst) prep_cnt = 0;
         else if (tgt_psen_n) prep_cnt++;
         else if (prev_psen)
            check(prep_cnt == PREP, "R2 preamble", prep_cnt, PREP);
         if (tgt_vpp_en && tgt_prog_n) vpp_cnt++;
         if (!tgt_prog_n && prev_prog) begin
            check(vpp_cnt == TS, "R5 setup", vpp_cnt, TS);
            check(tgt_p2_oe, "R4 oe", tgt_p2_oe, 1);
            check(tgt_p0 == cur_mode, "R3 mode", tgt_p0, cur_mode);
            tgt_mem[tgt_p3] = tgt_p2_out;
         end
         if (!tgt_vpp_en) vpp_cnt = 0;
         if (!tgt_prog_n) low_cnt++;
         else if (!prev_prog) begin
            check(low_cnt == TW, "R5 pulse", low_cnt, TW);
            low_cnt = 0;
         end
         if (tgt_vpp_en) settle_cnt = 0;
         else if (busy) settle_cnt++;
         if (done && cur_prog)
            check(settle_cnt == TT, "R6 settle", settle_cnt, TT);
         if (!busy) settle_cnt = 0;
         if (busy && !cur_prog)
            check(!tgt_vpp_en && !tgt_p2_oe, "R7 no drive", tgt_p2_oe, 0);
         prev_psen = tgt_psen_n;
         prev_prog = tgt_prog_n;
      end
   end

   task automatic run_op(input logic prog, input logic [15:0] addr,
                         input logic [7:0] data, input logic [7:0] mode,
                         input logic poke);
      int n = 0;
      int lat;
      lat = latency(prog, sess_open);
      cur_prog = prog;
      cur_mode = mode;
      cmd_prog = prog; cmd_addr = addr; cmd_wdata = data; cmd_mode = mode;
      cmd_start = 1'b1;
      while (n < 200) begin
         @(negedge clk);
         n++;
         cmd_start = 1'b0;
         cmd_close = 1'b0;
         if (n == 1) check(busy, "R10 busy", busy, 1);
         if (n == 2 && poke) begin
            // R8: start and close during busy
            cmd_start = 1'b1; cmd_close = 1'b1;
            cmd_addr = ~addr; cmd_wdata = ~data; cmd_prog = ~prog;
         end
         if (done) break;
      end
      check(n == lat + 1, prog ? "R6 latency" : "R7 latency", n, lat + 1);
      check(!busy, "R10 done idle", busy, 0);
      check({tgt_p1, tgt_p3} == addr, "R4 addr", {tgt_p1, tgt_p3}, addr);
      if (prog) begin
         check(tgt_p2_out == data, "R4 data", tgt_p2_out, data);
         exp_mem[addr[7:0]] = data;
      end else
         check(rdata == exp_mem[addr[7:0]], "R7 rdata", rdata, exp_mem[addr[7:0]]);
      sess_open = 1'b1;
      if (poke) begin
         repeat (3) @(negedge clk);
         check(!busy && tgt_rst && !tgt_psen_n, "R8 ignored", busy, 0);
      end
   endtask

   task automatic close_sess();
      cmd_close = 1'b1;
      @(negedge clk);
      cmd_close = 1'b0;
      check(!tgt_rst && tgt_psen_n && tgt_prog_n && tgt_p0 == 8'hFF && !tgt_vpp_en,
            "R9 close", {tgt_rst, tgt_psen_n}, 2'b01);
      sess_open = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] sig_a [4];
      logic [7:0] lo;
      sig_a = '{8'h30, 8'h31, 8'h60, 8'h61};
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin
         tgt_mem[i] = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
      end
      tgt_mem[8'h30] = 8'h58; exp_mem[8'h30] = 8'h58;
      tgt_mem[8'h31] = 8'h40; exp_mem[8'h31] = 8'h40;
      tgt_mem[8'h60] = 8'hF7; exp_mem[8'h60] = 8'hF7;
      tgt_mem[8'h61] = 8'hFD; exp_mem[8'h61] = 8'hFD;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!tgt_rst && tgt_psen_n && tgt_prog_n && tgt_p0 == 8'hFF &&
            !tgt_vpp_en && !tgt_p2_oe && !busy && !done,
            "R1 reset", {tgt_rst, busy, done}, 0);
      // directed: identification bytes read first, vendor byte at 30h
      for (int k = 0; k < 4; k++) run_op(1'b0, {8'h00, sig_a[k]}, 8'h00, 8'h0A, 1'b0);
      check(rdata == 8'hFD, "R7 last id byte", rdata, 8'hFD);
      // directed: program then read back, with ignored start and close
      run_op(1'b1, 16'h12A5, 8'h3C, 8'h21, 1'b1);
      run_op(1'b0, 16'h12A5, 8'h00, 8'h22, 1'b0);
      close_sess();
      // directed: verify opening a fresh session
      run_op(1'b0, 16'h0030, 8'h00, 8'h0A, 1'b0);
      close_sess();
      // random mix
      for (int k = 0; k < 40; k++) begin
         lo = ($urandom % 3 == 0) ? sig_a[$urandom % 4] : 8'($urandom);
         run_op(1'($urandom), {8'($urandom), lo}, 8'($urandom), 8'($urandom),
                1'($urandom % 5 == 0));
         if ($urandom % 6 == 0) close_sess();
         repeat ($urandom % 3) @(negedge clk);
      end
      close_sess();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule